// File: doc/BRIEF.md
# SPI Command Front End for a Digital Potentiometer Register Set

This block is the serial slave side of a digitally controlled resistor. It watches a mode-0 style serial link (select, clock, data in, pause), oversamples it with the chip clock, and turns each accepted frame into one command for a separate register bank. That bank holds the volatile wiper position, four stored wiper settings and a status word. The block itself stores only the frame in flight.

Every frame opens with an identification byte: a fixed device code and a two-bit address that must match two strap pins. The second byte carries an opcode and a register pointer. Transfers between a stored setting and the wiper take two bytes. Reads and writes of a 10-bit value take four bytes, and so does the status read. Writes and transfers reach the bank only when the select line rises after exactly the right number of bits. For reads, the block shows the opcode and pointer to the bank, latches the value the bank returns, and shifts it out on the serial output. A pause input freezes the frame without losing any bits.

Top module: `spi_pot_front`

## Requirements
- R1: The first byte must hold 0101 in bits 7:4, 0 in bit 3 and the strap pin value in bits 2:1. Bit 0 (read/write flag) is not checked. Any other first byte makes the rest of the frame ignored: no command is issued and SO is not driven.
- R2: SI is taken on SCK rising edges, most significant bit first. SO changes only after SCK falling edges.
- R3: In the second byte, bits 7:5 are the opcode and bits 3:2 the register pointer. Its other bits are ignored. Both fields appear on cmd_op and cmd_reg and stay there until the next accepted second byte.
- R4: Opcode 010 (stored setting to wiper) and opcode 011 (wiper to stored setting) are two-byte frames. When CS rises after exactly 16 bits, cmd_valid pulses with cmd_data equal to 0.
- R5: Opcode 101 (write wiper) and opcode 111 (write stored setting) are four-byte frames. The third byte gives data bits 7:0 and bits 1:0 of the fourth byte give data bits 9:8; the upper six bits of the fourth byte are ignored. When CS rises after exactly 32 bits, cmd_valid pulses with that data.
- R6: A frame whose bit count at CS rise differs from its opcode's length (short or overlong) issues no command.
- R7: Opcodes 100 (read wiper), 110 (read stored setting) and 001 (read status) are four-byte frames and issue no command. The value v returned on rd_data is latched after the second byte. It is shifted out as v[7:0], then 000000 followed by v[9:8], MSB first. The first bit is valid after the SCK fall that follows the 16th rising edge, and spi_so_oe is high while it is driven.
- R8: Opcode 000 is ignored: no command is issued and SO is not driven.
- R9: While CS is high, spi_so_oe is low, SCK activity has no effect, and the frame state is cleared.
- R10: After reset, nothing is accepted until CS has been seen high. A frame clocked while CS stayed low through reset is ignored.
- R11: HOLD low while SCK is low pauses the frame. SCK edges are then ignored and SO is released. HOLD high while SCK is low resumes with no bit lost.
- R12: cmd_valid is a one-clock pulse that is visible after the third clk rising edge following the CS rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| addr_pins | input | 2 | Strapped device address |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so (low means high impedance) |
| cmd_valid | output | 1 | One-clock command strobe to the bank |
| cmd_op | output | 3 | Opcode of the current or last frame |
| cmd_reg | output | 2 | Register pointer of the current or last frame |
| cmd_data | output | 10 | Write data accompanying cmd_valid |
| rd_data | input | 10 | Value the bank returns for cmd_op/cmd_reg |

## Verification
Two events can land in the same clock cycle. The first is the rising edge of CS, which issues the command and clears the frame. The second is the capture of the last data bit, which fills the data register that the command carries. The bench sends frames of exact, short and long length and checks that cmd_data on the strobe holds the bits of the closing byte. A second overlap is a pause arriving on the same SCK low phase as an SO update: the bench holds the frame paused across extra SCK toggles during a read and a write, then checks that SO stayed released and that the data and command came out unchanged.

// File: rtl/spi_pot_front.sv
module spi_pot_front #(
  parameter logic [3:0] DEV_ID = 4'b0101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_csn,
  input  logic       spi_si,
  input  logic       spi_hold_n,
  input  logic [1:0] addr_pins,
  output logic       spi_so,
  output logic       spi_so_oe,
  output logic       cmd_valid,
  output logic [2:0] cmd_op,
  output logic [1:0] cmd_reg,
  output logic [9:0] cmd_data,
  input  logic [9:0] rd_data
);
  localparam logic [2:0] OP_RD_W = 3'b100;
  localparam logic [2:0] OP_WR_W = 3'b101;
  localparam logic [2:0] OP_RD_D = 3'b110;
  localparam logic [2:0] OP_WR_D = 3'b111;
  localparam logic [2:0] OP_X_DW = 3'b010;
  localparam logic [2:0] OP_X_WD = 3'b011;
  localparam logic [2:0] OP_RD_S = 3'b001;
  localparam logic [5:0] LEN_SHORT = 6'd16;
  localparam logic [5:0] LEN_LONG  = 6'd32;

  logic [2:0] sck_sr, csn_sr;
  logic [1:0] hold_sr, si_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sr  <= '0;
      csn_sr  <= '0;
      hold_sr <= '1;
      si_sr   <= '0;
    end else begin
      sck_sr  <= {sck_sr[1:0], spi_sck};
      csn_sr  <= {csn_sr[1:0], spi_csn};
      hold_sr <= {hold_sr[0], spi_hold_n};
      si_sr   <= {si_sr[0], spi_si};
    end
  end

  wire sck_s    = sck_sr[1];
  wire csn_s    = csn_sr[1];
  wire hold_s   = hold_sr[1];
  wire si_s     = si_sr[1];
  wire sck_rise = sck_s & ~sck_sr[2];
  wire sck_fall = ~sck_s & sck_sr[2];
  wire csn_rise = csn_s & ~csn_sr[2];

  logic       armed, paused, drop, tx_on, ld_rd;
  logic [5:0] bit_cnt;
  logic [7:0] rx;
  logic [9:0] wr_data, rd_lat;

  wire [7:0] rx_nxt   = {rx[6:0], si_s};
  wire       two_byte = (cmd_op == OP_X_DW) || (cmd_op == OP_X_WD);
  wire       is_write = two_byte || (cmd_op == OP_WR_W) || (cmd_op == OP_WR_D);
  wire       is_read  = (cmd_op == OP_RD_W) || (cmd_op == OP_RD_D) || (cmd_op == OP_RD_S);
  wire [5:0] frame_len = two_byte ? LEN_SHORT : LEN_LONG;
  wire [15:0] tx_word = {rd_lat[7:0], 6'b000000, rd_lat[9:8]};
  wire [3:0] tx_idx   = 4'd15 - bit_cnt[3:0];
  wire       live     = armed & ~csn_s & ~paused;
  wire       id_ok    = (rx_nxt[7:4] == DEV_ID) && !rx_nxt[3] && (rx_nxt[2:1] == addr_pins);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      paused    <= 1'b0;
      drop      <= 1'b0;
      tx_on     <= 1'b0;
      ld_rd     <= 1'b0;
      bit_cnt   <= '0;
      rx        <= '0;
      wr_data   <= '0;
      rd_lat    <= '0;
      spi_so    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_reg   <= '0;
      cmd_data  <= '0;
    end else begin
      ld_rd     <= 1'b0;
      cmd_valid <= csn_rise & armed & ~drop & is_write & (bit_cnt == frame_len);
      if (csn_rise) cmd_data <= wr_data;
      if (ld_rd) rd_lat <= rd_data;
      if (csn_s) begin
        armed   <= 1'b1;
        paused  <= 1'b0;
        drop    <= 1'b0;
        tx_on   <= 1'b0;
        bit_cnt <= '0;
        rx      <= '0;
        wr_data <= '0;
      end else if (armed) begin
        if (!sck_s) paused <= ~hold_s;
        if (sck_rise && !paused) begin
          rx <= rx_nxt;
          if (bit_cnt != 6'd63) bit_cnt <= bit_cnt + 6'd1;
          case (bit_cnt)
            6'd7:  if (!id_ok) drop <= 1'b1;
            6'd15: if (!drop) begin
                     cmd_op  <= rx_nxt[7:5];
                     cmd_reg <= rx_nxt[3:2];
                     ld_rd   <= 1'b1;
                     if (rx_nxt[7:5] == 3'b000) drop <= 1'b1;
                   end
            6'd23: wr_data[7:0] <= rx_nxt;
            6'd31: wr_data[9:8] <= rx_nxt[1:0];
            default: ;
          endcase
        end
        if (sck_fall && !paused && bit_cnt >= LEN_SHORT && bit_cnt < LEN_LONG) begin
          spi_so <= tx_word[tx_idx];
          tx_on  <= 1'b1;
        end
      end
    end
  end

  assign spi_so_oe = live & ~drop & tx_on & is_read;

endmodule

module pot_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic       armed,
  input logic       paused,
  input logic [5:0] bit_cnt,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       spi_so_oe
);
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !spi_so_oe);
  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R8
  write_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 3'b101 || cmd_op == 3'b111 || cmd_op == 3'b010 || cmd_op == 3'b011));
  // R7
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_so_oe |-> (cmd_op == 3'b100 || cmd_op == 3'b110 || cmd_op == 3'b001));
  // R11
  pause_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !spi_so_oe);
  // R10
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!cmd_valid && !spi_so_oe));
  // R6
  exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(bit_cnt) == 6'd16 || $past(bit_cnt) == 6'd32));
endmodule

bind spi_pot_front pot_front_chk u_pot_front_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .armed(armed), .paused(paused),
  .bit_cnt(bit_cnt), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .spi_so_oe(spi_so_oe)
);

// File: tb/test_spi_pot_front.sv
module test_spi_pot_front;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic [1:0] addr_pins = 2'b10;
  logic spi_so, spi_so_oe, cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [9:0] cmd_data, rd_data;

  always #2 clk = ~clk;

  function automatic logic [9:0] bank_val(input logic [2:0] op, input logic [1:0] r);
    case (op)
      3'b100:  return 10'h1C6;
      3'b110:  return 10'h0F0 + 10'h055 * {8'd0, r};
      3'b001:  return 10'h001;
      default: return 10'h000;
    endcase
  endfunction

  assign rd_data = bank_val(cmd_op, cmd_reg);

  spi_pot_front i_spi_pot_front (.*);

  int checks = 0, fails = 0, pulses = 0;
  logic [2:0] p_op;
  logic [1:0] p_reg;
  logic [9:0] p_data;

  always @(negedge clk) if (cmd_valid) begin
    pulses <= pulses + 1;
    p_op   <= cmd_op;
    p_reg  <= cmd_reg;
    p_data <= cmd_data;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [31:0] frame, input int nbits, input int pause_at,
                           input bit raise, output logic [15:0] got, output logic oe_any,
                           output logic oe_all, output logic oe_pause);
    got = '0; oe_any = 0; oe_all = 1; oe_pause = 0;
    pulses = 0;
    @(negedge clk) spi_csn = 1'b0;
    clocks(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_si = frame[31-i];
      if (i == pause_at) begin
        spi_hold_n = 1'b0;
        clocks(HALF);
        for (int k = 0; k < 3; k++) begin
          spi_sck = 1'b1; clocks(HALF);
          oe_pause |= spi_so_oe;
          spi_sck = 1'b0; clocks(HALF);
          oe_pause |= spi_so_oe;
        end
        spi_hold_n = 1'b1;
      end
      clocks(HALF);
      oe_any |= spi_so_oe;
      if (i >= 16 && i < 32) begin
        got[31-i] = spi_so;
        oe_all &= spi_so_oe;
      end
      spi_sck = 1'b1; clocks(HALF);
      oe_any |= spi_so_oe;
      spi_sck = 1'b0;
    end
    clocks(HALF);
    if (raise) begin
      spi_csn = 1'b1;
      clocks(12);
    end
  endtask

  // {frame[31:0], nbits[5:0], expect command, expect SO data}
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {32'h54A0A502, 6'd32, 1'b1, 1'b0},  // R5 write wiper 0x2A5
    {32'h54ECFF03, 6'd32, 1'b1, 1'b0},  // R5 write stored 3 0x3FF
    {32'h54480000, 6'd16, 1'b1, 1'b0},  // R4 stored 2 to wiper
    {32'h54640000, 6'd16, 1'b1, 1'b0},  // R4 wiper to stored 1
    {32'h55800000, 6'd32, 1'b0, 1'b1},  // R7 read wiper
    {32'h55C80000, 6'd32, 1'b0, 1'b1},  // R7 read stored 2
    {32'h55200000, 6'd32, 1'b0, 1'b1},  // R7 read status
    {32'h52A0A502, 6'd32, 1'b0, 1'b0},  // R1 address mismatch
    {32'h74A0A502, 6'd32, 1'b0, 1'b0},  // R1 wrong device code
    {32'h5CA0A502, 6'd32, 1'b0, 1'b0},  // R1 bit 3 set
    {32'h54000000, 6'd32, 1'b0, 1'b0},  // R8 opcode 000
    {32'h54A0A500, 6'd24, 1'b0, 1'b0},  // R6 short write
    {32'h54480000, 6'd24, 1'b0, 1'b0},  // R6 long transfer
    {32'h54E012FD, 6'd32, 1'b1, 1'b0},  // R5 upper bits of byte 4 ignored
    {32'h53800000, 6'd32, 1'b0, 1'b0}   // R1 read with wrong address
  };

  task automatic apply(input logic [39:0] v, input int pause_at, input string tag);
    logic [31:0] fr; logic [15:0] got; logic oe_any, oe_all, oe_pause;
    logic [2:0] op; logic [1:0] rg; logic [9:0] ev, rv;
    fr = v[39:8];
    op = fr[23:21]; rg = fr[19:18];
    ev = (op == 3'b101 || op == 3'b111) ? {fr[1:0], fr[15:8]} : 10'h000;
    run_frame(fr, int'(v[7:2]), pause_at, 1'b1, got, oe_any, oe_all, oe_pause);
    check(pulses == int'(v[1]), {tag, " command count"}, pulses, v[1]);
    if (v[1]) begin
      check(p_op == op, {tag, " R3 opcode"}, p_op, op);
      check(p_reg == rg, {tag, " R3 pointer"}, p_reg, rg);
      check(p_data == ev, {tag, " data"}, p_data, ev);
    end
    if (v[0]) begin
      rv = bank_val(op, rg);
      check(got == {rv[7:0], 6'b0, rv[9:8]}, {tag, " R2 SO stream"}, got, {rv[7:0], 6'b0, rv[9:8]});
      check(oe_all, {tag, " SO driven"}, oe_all, 1);
    end else begin
      check(!oe_any, {tag, " SO released"}, oe_any, 0);
    end
    if (pause_at >= 0) check(!oe_pause, {tag, " R11 SO released in pause"}, oe_pause, 0);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] got; logic oe_any, oe_all, oe_pause;
    clocks(5);
    check(!spi_so_oe && !cmd_valid, "R9 reset state", {spi_so_oe, cmd_valid}, 0);
    rst_n = 1'b1;
    clocks(5);
    // R9: SCK activity with CS high
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      spi_si = k[0]; spi_sck = 1'b1; clocks(HALF);
      check(!spi_so_oe, "R9 SO released while CS high", spi_so_oe, 0);
      spi_sck = 1'b0; clocks(HALF);
    end
    check(pulses == 0, "R9 no command while CS high", pulses, 0);

    for (int n = 0; n < NV; n++) apply(VEC[n], -1, $sformatf("vec%0d", n));

    // R11 pause inside a write and inside a read
    apply({32'h54A13902, 6'd32, 1'b1, 1'b0}, 20, "R11 write paused");
    apply({32'h55CC0000, 6'd32, 1'b0, 1'b1}, 21, "R11 read paused");

    // R12 latency of the strobe
    run_frame(32'h54A0A502, 32, -1, 1'b0, got, oe_any, oe_all, oe_pause);
    spi_csn = 1'b1;
    clocks(1); check(!cmd_valid, "R12 edge 1", cmd_valid, 0);
    clocks(1); check(!cmd_valid, "R12 edge 2", cmd_valid, 0);
    clocks(1); check(cmd_valid, "R12 edge 3", cmd_valid, 1);
    clocks(1); check(!cmd_valid, "R12 one clock", cmd_valid, 0);
    clocks(12);

    // R10 CS low through reset
    spi_csn = 1'b0;
    rst_n = 1'b0; clocks(4); rst_n = 1'b1; clocks(4);
    run_frame(32'h54A0A502, 32, -1, 1'b1, got, oe_any, oe_all, oe_pause);
    check(pulses == 0, "R10 frame before CS high ignored", pulses, 0);
    run_frame(32'h55800000, 32, -1, 1'b1, got, oe_any, oe_all, oe_pause);
    check(got == {8'hC6, 6'b0, 2'b01}, "R10 accepted after CS high", got, {8'hC6, 6'b0, 2'b01});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule